// File: doc/BRIEF.md
# Disk sector staging buffer

This block sits between a floppy disk controller and a host CPU bus and gathers one whole disk sector into a local RAM. The CPU takes no part in the transfer. Each data-ready strobe from the disk controller is synchronised into the block clock and edge-detected. On that edge the byte on the disk data bus is written at the current fill address, and the fill counter advances by one.

The CPU is notified once per sector, not once per byte. When the fill count reaches the selected sector length, an interrupt is raised. The CPU then drains the buffer at its own pace through a data register that advances its own read pointer on each read. A write to the control register rearms the block for the next sector.

A mode input selects a 256-byte or a 512-byte sector. The 512-byte mode uses one extra address bit.

Top module: `sector_stage_buf`

## Requirements
- R1: Each rising edge of `dsk_rdy_i` writes `dsk_data_i` into the buffer at the current fill count and increments the fill count by exactly one. A strobe held high for several cycles causes only one write.
- R2: With `size_512_i`=0 the sector length is 256 bytes. With `size_512_i`=1 it is 512 bytes.
- R3: `irq_o` stays low while the fill count is below the sector length. It goes high once the count equals the sector length, and it stays high until cleared.
- R4: A host read (`host_rd_i`=1) at address 0 returns the stored byte at the read pointer in bits 7:0, with bits 15:8 zero. The pointer then advances by one, so consecutive reads return the bytes in arrival order.
- R5: A read at address 1 returns status: bit 15 is sector complete, bit 14 is overrun, bits 9:0 are the fill count, and all other bits are zero. A read at address 3 returns zero.
- R6: A strobe edge that arrives while the sector is full is ignored. The fill count and the stored bytes do not change, and a sticky overrun flag is set.
- R7: A host write (`host_we_i`=1) at address 2 clears `irq_o`, the complete flag, the overrun flag, the fill count and the read pointer.
- R8: When a clear and a strobe write fall in the same cycle, the new byte is stored at address 0 and the fill count becomes 1, with both flags cleared.
- R9: After reset `irq_o` is low and the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dsk_rdy_i | input | 1 | Data-ready strobe from the disk controller, asynchronous |
| dsk_data_i | input | 8 | Disk data byte, held stable around the strobe |
| size_512_i | input | 1 | Sector size select: 0 for 256 bytes, 1 for 512 bytes |
| host_rd_i | input | 1 | Host read strobe for one cycle |
| host_we_i | input | 1 | Host write strobe for one cycle |
| host_addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| host_rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Sector-complete interrupt |

## Verification
The clear from the host and a byte write from the disk side can land in the same clock edge. The bench first fills a sector and overruns it, so that both flags are set. It then raises the strobe and issues the control write in the exact cycle when the synchronised edge reaches the write logic. The outcome is judged through the status register and a data read. The fill count must be 1, both flags must be clear, and the byte read back from address 0 must be the one that was strobed.

// File: rtl/sstg_pkg.sv
package sstg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned HOST_W = 16;
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam int unsigned STAT_DONE_BIT = 15;
  localparam int unsigned STAT_OVR_BIT  = 14;
endpackage

// File: rtl/sstg_edge_sync.sv
module sstg_edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], async_i};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise_o = sync_q[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/sstg_fill_ctrl.sv
module sstg_fill_ctrl #(
  parameter int unsigned BASE_AW = 8,
  localparam int unsigned AW = BASE_AW + 1,
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          clr_i,
  input  logic          size_big_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] fill_o,
  output logic          done_o,
  output logic          ovr_o
);
  logic [CW-1:0] fill_q, sect_len;
  logic          done_q, ovr_q, full;

  assign sect_len = size_big_i ? CW'(1 << (BASE_AW + 1)) : CW'(1 << BASE_AW);
  assign full     = fill_q >= sect_len;
  // clear frees the sector, so a coincident byte still lands at address 0
  assign we_o     = rise_i & (clr_i | ~full);
  assign waddr_o  = clr_i ? '0 : fill_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (clr_i) begin
      fill_q <= rise_i ? CW'(1) : '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (we_o) begin
        fill_q <= fill_q + 1'b1;
        if (fill_q + 1'b1 == sect_len) done_q <= 1'b1;
      end
      if (rise_i && full) ovr_q <= 1'b1;
    end
  end

  assign fill_o = fill_q;
  assign done_o = done_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/sstg_ram.sv
module sstg_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sector_stage_buf.sv
module sector_stage_buf
  import sstg_pkg::*;
#(
  parameter int unsigned BASE_AW = 8,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned AW = BASE_AW + 1,
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dsk_rdy_i,
  input  logic [DATA_W-1:0] dsk_data_i,
  input  logic              size_512_i,
  input  logic              host_rd_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_addr_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic              rise, clr, ram_we, done, ovr;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     rptr_q;
  logic [CW-1:0]     fill;
  logic [DATA_W-1:0] ram_rdata;

  assign clr = host_we_i && host_addr_i == REG_CTRL;

  sstg_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .async_i(dsk_rdy_i), .rise_o(rise)
  );

  sstg_fill_ctrl #(.BASE_AW(BASE_AW)) u_fill (
    .clk_i, .rst_ni, .rise_i(rise), .clr_i(clr), .size_big_i(size_512_i),
    .we_o(ram_we), .waddr_o(waddr), .fill_o(fill), .done_o(done), .ovr_o(ovr)
  );

  sstg_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .clk_i, .we_i(ram_we), .waddr_i(waddr), .wdata_i(dsk_data_i),
    .raddr_i(rptr_q), .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rptr_q <= '0;
    else if (clr)                                rptr_q <= '0;
    else if (host_rd_i && host_addr_i == REG_DATA) rptr_q <= rptr_q + 1'b1;
  end

  always_comb begin
    host_rdata_o = '0;
    unique case (host_addr_i)
      REG_DATA: host_rdata_o[DATA_W-1:0] = ram_rdata;
      REG_STAT: begin
        host_rdata_o[STAT_DONE_BIT] = done;
        host_rdata_o[STAT_OVR_BIT]  = ovr;
        host_rdata_o[CW-1:0]        = fill;
      end
      default: host_rdata_o = '0;
    endcase
  end

  assign irq_o = done;
endmodule

// File: rtl/sector_stage_buf_chk.sv
module sector_stage_buf_chk #(
  parameter int unsigned BASE_AW = 8,
  localparam int unsigned CW = BASE_AW + 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          size_512_i,
  input logic          rise,
  input logic          clr,
  input logic          ram_we,
  input logic          ovr,
  input logic [CW-1:0] fill
);
  logic [CW-1:0] len;
  assign len = size_512_i ? CW'(1 << (BASE_AW + 1)) : CW'(1 << BASE_AW);

  // R3
  irq_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> fill >= len);
  // R1
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && !clr) |=> fill == $past(fill) + 1'b1);
  // R6
  no_write_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill >= len && !clr) |-> !ram_we);
  // R6
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && !clr) |=> ovr);
  // R7
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !rise) |=> (!irq_o && !ovr && fill == '0));
  // R8
  clr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && rise) |=> (fill == CW'(1) && !irq_o));
endmodule

bind sector_stage_buf sector_stage_buf_chk #(.BASE_AW(BASE_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .size_512_i(size_512_i),
  .rise(rise), .clr(clr), .ram_we(ram_we), .ovr(ovr), .fill(fill)
);

// File: tb/sector_stage_buf_test.sv
module sector_stage_buf_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dsk_rdy_i = 1'b0;
  logic [7:0]  dsk_data_i = '0;
  logic        size_512_i = 1'b0;
  logic        host_rd_i = 1'b0;
  logic        host_we_i = 1'b0;
  logic [1:0]  host_addr_i = '0;
  logic [15:0] host_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  sector_stage_buf uut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + (i >> 3)) ^ (i >> 5));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] d, input int hold);
    @(negedge clk_i);
    dsk_data_i = d;
    dsk_rdy_i  = 1'b1;
    repeat (hold) @(negedge clk_i);
    dsk_rdy_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic hread(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk_i);
    host_addr_i = a;
    host_rd_i   = 1'b1;
    #1 v = host_rdata_o;
    @(negedge clk_i);
    host_rd_i = 1'b0;
  endtask

  task automatic hclear();
    @(negedge clk_i);
    host_addr_i = 2'd2;
    host_we_i   = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic run_sector(input logic big, input int seed);
    int len;
    len = big ? 512 : 256;
    size_512_i = big;
    hclear();
    for (int i = 0; i < len; i++) begin
      strobe(pat(i, seed), (i % 3 == 0) ? 6 : 4);
      if (i == len - 2 || i < 3) begin
        hread(2'd1, rd);
        chk("R1 fill count", rd, 16'(i + 1));
        chk("R3 irq early", {15'd0, irq_o}, 16'd0);
      end
    end
    #1 chk("R2/R3 irq at length", {15'd0, irq_o}, 16'd1);
    hread(2'd1, rd);
    chk("R5 status full", rd, 16'h8000 | 16'(len));
    for (int i = 0; i < len; i++) begin
      hread(2'd0, rd);
      chk("R4 readback", rd, {8'h00, pat(i, seed)});
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk("R9 irq reset", {15'd0, irq_o}, 16'd0);
    rst_ni = 1'b1;
    hread(2'd1, rd);
    chk("R9 status reset", rd, 16'h0000);
    hread(2'd3, rd);
    chk("R5 unused addr", rd, 16'h0000);

    run_sector(1'b0, 1);

    // R6: overrun in 256 mode
    strobe(8'hEE, 4);
    strobe(8'hDD, 4);
    hread(2'd1, rd);
    chk("R6 overrun status", rd, 16'hC000 | 16'd256);
    hclear();
    hread(2'd1, rd);
    chk("R7 status cleared", rd, 16'h0000);
    #1 chk("R7 irq cleared", {15'd0, irq_o}, 16'd0);
    for (int i = 0; i < 4; i++) begin
      hread(2'd0, rd);
      chk("R7/R6 pointer reset, content kept", rd, {8'h00, pat(i, 1)});
    end

    run_sector(1'b1, 2);
    strobe(8'h5A, 4);
    hread(2'd1, rd);
    chk("R6 overrun 512", rd, 16'hC000 | 16'd512);
    hclear();
    hread(2'd0, rd);
    chk("R6 ignored byte", rd, {8'h00, pat(0, 2)});

    // R8: refill, overrun, then clear coinciding with the write edge
    run_sector(1'b0, 3);
    strobe(8'h11, 4);
    @(negedge clk_i);
    dsk_data_i = 8'hA7;
    dsk_rdy_i  = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    host_addr_i = 2'd2;
    host_we_i   = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    dsk_rdy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    hread(2'd1, rd);
    chk("R8 coincident clear status", rd, 16'h0001);
    hread(2'd0, rd);
    chk("R8 coincident byte", rd, 16'h00A7);
    #1 chk("R8 irq low", {15'd0, irq_o}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule